// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a small load/store processor core. Every instruction completes in one clock cycle. In each cycle the core presents the program counter on an instruction-fetch port and decodes the returned 32-bit word. It reads two operands from a 32-entry register file, computes a result or a byte address in its ALU, and then does three things at the same clock edge: it writes back, it stores, and it selects the next program counter. The supported work is register and immediate arithmetic, signed comparison, logical operations with zero-extended constants, upper-half constant loads, word loads and stores, two conditional PC-relative branches and one region-limited absolute jump.

Both memories sit outside the core and are read combinationally in the same cycle. Stores are committed by the memory at the rising clock edge while the write strobe is high. Addresses are byte addresses, and software keeps word accesses aligned. An asynchronous active-low reset is released into the core through a two-stage synchronizer. The program counter therefore leaves its reset value on the third rising edge after the reset input goes high.

Top module: `scp_core`

## Requirements
- R1: While the core is held in reset, `imem_addr` equals RESET_PC (default 0) and `dmem_we` is low. After reset is released, `imem_addr` stays at RESET_PC for two rising edges and then advances.
- R2: An opcode-0 word adds rs (bits 25:21) and rt (bits 20:16), or subtracts rt from rs, or sets a signed less-than result, and writes the result into rd (bits 15:11). The operation is chosen by the low six bits: 32 for add, 34 for subtract, 42 for less-than.
- R3: Opcode 8 writes rs plus the sign-extended low 16 bits into rt. Opcode 10 writes the signed less-than of rs against the sign-extended immediate into rt. Opcodes 12 and 13 write the AND or the OR of rs with the zero-extended immediate into rt.
- R4: Opcode 15 writes the 16-bit immediate into the upper half of rt and zeros into the lower half. Following it with opcode 13 on the same register produces any 32-bit constant.
- R5: Opcode 35 reads the word at byte address rs plus the sign-extended offset into rt. Opcode 43 drives rt on `dmem_wdata` to that same address with `dmem_we` high. No other instruction raises `dmem_we`, and a store writes no register.
- R6: Register 0 always reads as zero. Arithmetic results and loads that target it are discarded.
- R7: Opcode 4 (operands equal) and opcode 5 (operands differ) go to PC+4 plus the sign-extended offset times four when their condition holds. Otherwise they go to PC+4. This applies to forward and backward offsets alike.
- R8: Opcode 2 goes to the top four bits of PC+4, followed by the 26-bit target field, followed by two zero bits.
- R9: An unknown opcode, or an opcode-0 word with an unknown low field, writes no register, stores nothing and advances the PC by 4.
- R10: The less-than operations compare as two's-complement signed values and produce exactly 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally through two flops |
| imem_addr | output | 32 | Byte address of the instruction being fetched (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata | input | 32 | Word at `dmem_addr`, valid in the same cycle |

## Verification
The arithmetic and logic path is swept over every ordered pair drawn from eight operand values. The set includes zero, one, minus one, both extremes of the signed range and mixed-sign constants. Each pair separates signed from unsigned comparison, sign extension from zero extension of the immediate, and carry or borrow across the half-word boundary. Separate programs cover the following: loads and stores with positive and negative offsets, writes aimed at register 0, taken and untaken branches in both directions (including a counted backward loop), and a jump traced cycle by cycle on two cores whose PCs sit in different 256 MB regions. A final program mixes unknown opcodes and unknown function codes with ordinary instructions to show they leave no trace.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_ADDI    = 6'd8;
  localparam logic [5:0] OP_SLTI    = 6'd10;
  localparam logic [5:0] OP_ANDI    = 6'd12;
  localparam logic [5:0] OP_ORI     = 6'd13;
  localparam logic [5:0] OP_LUI     = 6'd15;
  localparam logic [5:0] OP_LW      = 6'd35;
  localparam logic [5:0] OP_SW      = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_AND,
    ALU_OR,
    ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SEXT,
    IMM_ZEXT,
    IMM_HIGH
  } imm_mode_e;

  typedef struct packed {
    logic      legal;
    logic      reg_we;
    logic      dst_is_rd;
    logic      use_imm;
    imm_mode_e imm;
    alu_op_e   alu;
    logic      mem_we;
    logic      wb_mem;
    logic      br_eq;
    logic      br_ne;
    logic      jump;
  } ctrl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctl,
  output logic [RIDX-1:0] rs,
  output logic [RIDX-1:0] rt,
  output logic [RIDX-1:0] rd,
  output logic [15:0]     imm16,
  output logic [25:0]     tgt26
);

  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign imm16  = instr[15:0];
  assign tgt26  = instr[25:0];

  always_comb begin
    ctl     = '0;
    ctl.alu = ALU_ADD;
    ctl.imm = IMM_SEXT;
    unique case (opcode)
      OP_SPECIAL: begin
        ctl.dst_is_rd = 1'b1;
        unique case (funct)
          FN_ADD: begin ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.alu = ALU_ADD; end
          FN_SUB: begin ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.alu = ALU_SUB; end
          FN_SLT: begin ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.alu = ALU_SLT; end
          default: ctl.dst_is_rd = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm = IMM_SEXT; ctl.alu = ALU_ADD;
      end
      OP_SLTI: begin
        ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm = IMM_SEXT; ctl.alu = ALU_SLT;
      end
      OP_ANDI: begin
        ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm = IMM_ZEXT; ctl.alu = ALU_AND;
      end
      OP_ORI: begin
        ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm = IMM_ZEXT; ctl.alu = ALU_OR;
      end
      OP_LUI: begin
        ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
        ctl.imm = IMM_HIGH; ctl.alu = ALU_PASSB;
      end
      OP_LW: begin
        ctl.legal = 1'b1; ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      OP_SW: begin
        ctl.legal = 1'b1; ctl.use_imm = 1'b1; ctl.mem_we = 1'b1;
      end
      OP_BEQ:  begin ctl.legal = 1'b1; ctl.br_eq = 1'b1; end
      OP_BNE:  begin ctl.legal = 1'b1; ctl.br_ne = 1'b1; end
      OP_JUMP: begin ctl.legal = 1'b1; ctl.jump  = 1'b1; end
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = XLEN,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [NREG-1:0][DW-1:0] entry_q;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign entry_q[g] = '0;
    end else begin : g_store
      logic          wen;
      logic [DW-1:0] val_q;
      assign wen = we && (waddr == AW'(g));
      always_ff @(posedge clk) begin
        if (wen) val_q <= wdata;
      end
      assign entry_q[g] = val_q;
    end
  end

  assign rdata_a = entry_q[raddr_a];
  assign rdata_b = entry_q[raddr_b];

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  alu_op_e       op,
  output logic [DW-1:0] result
);

  logic less;

  assign less = $signed(opnd_a) < $signed(opnd_b);

  always_comb begin
    unique case (op)
      ALU_ADD:   result = opnd_a + opnd_b;
      ALU_SUB:   result = opnd_a - opnd_b;
      ALU_SLT:   result = {{(DW-1){1'b0}}, less};
      ALU_AND:   result = opnd_a & opnd_b;
      ALU_OR:    result = opnd_a | opnd_b;
      ALU_PASSB: result = opnd_b;
      default:   result = '0;
    endcase
  end

endmodule

// File: rtl/scp_nextpc.sv
module scp_nextpc
  import scp_pkg::*;
#(
  parameter int DW = XLEN,
  localparam int REGION_BITS = 4
) (
  input  logic [DW-1:0] pc,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          jump,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [15:0]   imm16,
  input  logic [25:0]   tgt26,
  output logic [DW-1:0] pc_inc,
  output logic [DW-1:0] pc_next
);

  logic [DW-1:0] br_off;
  logic [DW-1:0] jmp_tgt;
  logic          same;
  logic          taken;

  assign pc_inc  = pc + DW'(4);
  assign br_off  = {{(DW-18){imm16[15]}}, imm16, 2'b00};
  assign jmp_tgt = {pc_inc[DW-1 -: REGION_BITS], tgt26, 2'b00};
  assign same    = (opnd_a == opnd_b);
  assign taken   = (br_eq && same) || (br_ne && !same);

  always_comb begin
    if (jump)       pc_next = jmp_tgt;
    else if (taken) pc_next = pc_inc + br_off;
    else            pc_next = pc_inc;
  end

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              NREG     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  // reset release synchronizer
  logic rst_meta;
  logic core_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      core_run <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      core_run <= rst_meta;
    end
  end

  // program counter
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_inc;
  logic            pc_en;

  assign pc_en = core_run;

  always_ff @(posedge clk or negedge core_run) begin
    if (!core_run)  pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  // decode
  ctrl_t           ctl;
  logic [RIDX-1:0] f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;

  scp_decode u_dec (
    .instr (imem_rdata),
    .ctl   (ctl),
    .rs    (f_rs),
    .rt    (f_rt),
    .rd    (f_rd),
    .imm16 (f_imm),
    .tgt26 (f_tgt)
  );

  // operands and write-back
  logic [XLEN-1:0] rs_val, rt_val;
  logic [XLEN-1:0] imm_ext, alu_b, alu_y, wb_data;
  logic [AW-1:0]   wb_addr;
  logic            rf_we;

  assign rf_we   = ctl.reg_we && core_run;
  assign wb_addr = ctl.dst_is_rd ? AW'(f_rd) : AW'(f_rt);
  assign wb_data = ctl.wb_mem ? dmem_rdata : alu_y;

  scp_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (AW'(f_rs)),
    .raddr_b (AW'(f_rt)),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  always_comb begin
    unique case (ctl.imm)
      IMM_ZEXT: imm_ext = {{(XLEN-16){1'b0}}, f_imm};
      IMM_HIGH: imm_ext = {f_imm, {(XLEN-16){1'b0}}};
      default:  imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};
    endcase
  end

  assign alu_b = ctl.use_imm ? imm_ext : rt_val;

  scp_alu #(.DW(XLEN)) u_alu (
    .opnd_a (rs_val),
    .opnd_b (alu_b),
    .op     (ctl.alu),
    .result (alu_y)
  );

  // data memory port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we && core_run;

  // next program counter
  scp_nextpc #(.DW(XLEN)) u_npc (
    .pc      (pc_q),
    .br_eq   (ctl.br_eq),
    .br_ne   (ctl.br_ne),
    .jump    (ctl.jump),
    .opnd_a  (rs_val),
    .opnd_b  (rt_val),
    .imm16   (f_imm),
    .tgt26   (f_tgt),
    .pc_inc  (pc_inc),
    .pc_next (pc_d)
  );

  // assertions
  p_reset_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |=> (imem_addr == RESET_PC));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> !dmem_we);

  p_pc_aligned_r7: assert property (@(posedge clk) disable iff (!core_run)
    imem_addr[1:0] == 2'b00);

  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (!core_run)
    dmem_we |-> !rf_we);

  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!core_run)
    !ctl.legal |-> (!dmem_we && !rf_we));

  p_unknown_step_r9: assert property (@(posedge clk) disable iff (!core_run)
    !ctl.legal |=> (pc_q == $past(pc_q) + XLEN'(4)));

  p_jump_region_r8: assert property (@(posedge clk) disable iff (!core_run)
    ctl.jump |=> (pc_q[XLEN-1 -: 4] == $past(pc_inc[XLEN-1 -: 4])));

  p_branch_fall_r7: assert property (@(posedge clk) disable iff (!core_run)
    (ctl.br_eq && (rs_val != rt_val)) |=> (pc_q == $past(pc_inc)));

endmodule

// File: tb/sim_scp_core.sv
module sim_scp_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dm_init = 1'b0;
  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];
  int          st_cnt;

  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem_addr1, imem_rdata1, dmem_addr1, dmem_wdata1;
  logic        dmem_we1;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [31:0] tr0 [0:15];
  logic [31:0] tr1 [0:15];
  logic [31:0] rst_addr;
  logic        rst_we;

  always #10 clk = ~clk;

  assign imem_rdata  = imem[imem_addr[7:2]];
  assign imem_rdata1 = imem[imem_addr1[7:2]];
  assign dmem_rdata  = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dm_init) begin
      for (int i = 0; i < 64; i++) dmem[i] <= 32'hA000_0000 + 32'(i);
      st_cnt <= 0;
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      st_cnt <= st_cnt + 1;
    end
  end

  scp_core u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  scp_core #(.RESET_PC(32'h3000_0000)) u1 (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr1), .imem_rdata(imem_rdata1),
    .dmem_addr(dmem_addr1), .dmem_wdata(dmem_wdata1),
    .dmem_we(dmem_we1), .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] enc_j(int op, logic [25:0] t);
    return {op[5:0], t};
  endfunction

  function automatic logic [31:0] val(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h1234_8765;
      6: return 32'hFFFF_FFFB;
      default: return 32'h0000_7FFF;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fill_loops();
    for (int k = 0; k < 64; k++) imem[k] = enc_j(2, 26'(k));
  endtask

  task automatic run_prog(input int cyc);
    @(negedge clk);
    rst_n   = 1'b0;
    dm_init = 1'b1;
    repeat (2) @(negedge clk);
    rst_addr = imem_addr;
    rst_we   = dmem_we;
    dm_init  = 1'b0;
    rst_n    = 1'b1;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (k < 16) begin
        tr0[k] = imem_addr;
        tr1[k] = imem_addr1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, sb, zb;

    // R2 R3 R4 R10: operand sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a  = val(i);
        b  = val(j);
        sb = {{16{b[15]}}, b[15:0]};
        zb = {16'h0000, b[15:0]};
        fill_loops();
        imem[0]  = enc_i(15, 0, 1, a[31:16]);
        imem[1]  = enc_i(13, 1, 1, a[15:0]);
        imem[2]  = enc_i(15, 0, 2, b[31:16]);
        imem[3]  = enc_i(13, 2, 2, b[15:0]);
        imem[4]  = enc_r(1, 2, 3, 32);
        imem[5]  = enc_r(1, 2, 4, 34);
        imem[6]  = enc_r(1, 2, 5, 42);
        imem[7]  = enc_i(8, 1, 6, b[15:0]);
        imem[8]  = enc_i(10, 1, 7, b[15:0]);
        imem[9]  = enc_i(12, 1, 8, b[15:0]);
        imem[10] = enc_i(13, 1, 9, b[15:0]);
        imem[11] = enc_i(15, 0, 10, b[15:0]);
        imem[12] = enc_i(43, 0, 1, 16'd0);
        imem[13] = enc_i(43, 0, 3, 16'd4);
        imem[14] = enc_i(43, 0, 4, 16'd8);
        imem[15] = enc_i(43, 0, 5, 16'd12);
        imem[16] = enc_i(43, 0, 6, 16'd16);
        imem[17] = enc_i(43, 0, 7, 16'd20);
        imem[18] = enc_i(43, 0, 8, 16'd24);
        imem[19] = enc_i(43, 0, 9, 16'd28);
        imem[20] = enc_i(43, 0, 10, 16'd32);
        run_prog(32);
        check("R4 lui+ori constant", dmem[0], a);
        check("R2 add", dmem[1], a + b);
        check("R2 sub", dmem[2], a - b);
        check("R10 slt signed", dmem[3], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R3 addi sext", dmem[4], a + sb);
        check("R10 slti signed", dmem[5], ($signed(a) < $signed(sb)) ? 32'd1 : 32'd0);
        check("R3 andi zext", dmem[6], a & zb);
        check("R3 ori zext", dmem[7], a | zb);
        check("R4 lui low zero", dmem[8], {b[15:0], 16'h0000});
      end
    end

    // R5 R6: loads, stores, register 0
    fill_loops();
    imem[0] = enc_i(8, 0, 11, 16'd16);
    imem[1] = enc_i(35, 11, 12, 16'hFFF8);
    imem[2] = enc_i(43, 0, 12, 16'd40);
    imem[3] = enc_i(35, 11, 13, 16'd4);
    imem[4] = enc_i(43, 11, 13, 16'hFFF4);
    imem[5] = enc_i(8, 0, 0, 16'd77);
    imem[6] = enc_i(15, 0, 0, 16'h1234);
    imem[7] = enc_i(35, 11, 0, 16'd0);
    imem[8] = enc_i(43, 0, 0, 16'd44);
    run_prog(20);
    check("R5 lw negative offset", dmem[10], 32'hA000_0002);
    check("R5 sw negative offset", dmem[1], 32'hA000_0005);
    check("R6 r0 stays zero", dmem[11], 32'h0000_0000);
    check("R5 untouched word", dmem[3], 32'hA000_0003);
    check("R5 store strobe count", 32'(st_cnt), 32'd3);

    // R7: branches
    fill_loops();
    imem[0]  = enc_i(8, 0, 1, 16'd5);
    imem[1]  = enc_i(8, 0, 2, 16'd5);
    imem[2]  = enc_i(8, 0, 3, 16'd99);
    imem[3]  = enc_i(4, 1, 2, 16'd1);
    imem[4]  = enc_i(8, 0, 3, 16'd1);
    imem[5]  = enc_i(5, 1, 2, 16'd1);
    imem[6]  = enc_i(8, 0, 4, 16'd7);
    imem[7]  = enc_i(8, 0, 5, 16'd3);
    imem[8]  = enc_i(8, 0, 6, 16'd0);
    imem[9]  = enc_i(8, 5, 5, 16'hFFFF);
    imem[10] = enc_i(8, 6, 6, 16'd1);
    imem[11] = enc_i(5, 5, 0, 16'hFFFD);
    imem[12] = enc_i(4, 1, 0, 16'd1);
    imem[13] = enc_i(8, 0, 7, 16'd42);
    imem[14] = enc_i(43, 0, 3, 16'd0);
    imem[15] = enc_i(43, 0, 4, 16'd4);
    imem[16] = enc_i(43, 0, 6, 16'd8);
    imem[17] = enc_i(43, 0, 7, 16'd12);
    imem[18] = enc_i(43, 0, 5, 16'd16);
    run_prog(40);
    check("R7 beq taken skips", dmem[0], 32'd99);
    check("R7 bne untaken falls", dmem[1], 32'd7);
    check("R7 backward loop count", dmem[2], 32'd3);
    check("R7 beq untaken falls", dmem[3], 32'd42);
    check("R7 loop exit value", dmem[4], 32'd0);

    // R1 R8: reset state and jump trace
    fill_loops();
    imem[0] = enc_i(8, 0, 8, 16'd11);
    imem[1] = enc_j(2, 26'd5);
    imem[2] = enc_i(8, 0, 8, 16'd22);
    imem[5] = enc_i(43, 0, 8, 16'd0);
    run_prog(12);
    check("R1 reset pc", rst_addr, 32'd0);
    check("R1 reset no store", {31'd0, rst_we}, 32'd0);
    check("R1 held edge1", tr0[0], 32'd0);
    check("R1 held edge2", tr0[1], 32'd0);
    check("R1 first step", tr0[2], 32'd4);
    check("R8 jump target", tr0[3], 32'd20);
    check("R8 after jump", tr0[4], 32'd24);
    check("R8 skipped word", dmem[0], 32'd11);
    check("R8 region start", tr1[1], 32'h3000_0000);
    check("R8 region jump", tr1[3], 32'h3000_0014);

    // R9: unknown encodings
    fill_loops();
    imem[0] = enc_i(8, 0, 7, 16'd5);
    imem[1] = {6'h3F, 5'd0, 5'd7, 16'd1};
    imem[2] = enc_r(0, 0, 7, 63);
    imem[3] = {6'd3, 26'd20};
    imem[4] = enc_i(43, 0, 7, 16'd0);
    run_prog(16);
    check("R9 pc step a", tr0[3], 32'd8);
    check("R9 pc step b", tr0[4], 32'd12);
    check("R9 pc step c", tr0[5], 32'd16);
    check("R9 no register write", dmem[0], 32'd5);
    check("R9 no extra store", 32'(st_cnt), 32'd1);
    check("R9 memory untouched", dmem[5], 32'hA000_0005);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule